// File: doc/BRIEF.md
# Link Equalization Phase Controller

This block is the per-port sequencer that walks a serial link through the four equalization phases (0 to 3) when the link is about to run at 8 GT/s. It decides which phase the port is in and which equalization-control (EC) code the port puts in its outgoing training sets. It captures the transmitter preset and receiver hint the partner asks for, and the partner's Full Swing and Low Frequency values. When the sequence ends it raises a done flag. If any phase stalls past a programmable limit it raises a fail flag instead. The error-rate verdict, the signal-quality verdict and the end of each fine-tuning step come from neighbouring logic as plain input flags. This block only sequences.

The role input selects the behaviour in phase 0. A downstream port leaves phase 0 when the rate change completes. An upstream port ignores the rate change and waits for two consecutive TS1 ordered sets with the same EC plus an acceptable error rate. In phase 1 the port can either finish at once, when no fine tuning is needed, or continue through phase 2 (upstream transmitter tuning) and phase 3 (downstream transmitter tuning).

States: `ST_IDLE`, `ST_PH0`, `ST_PH1`, `ST_PH2`, `ST_PH3`. Transitions:
- IDLE to PH0 on an accepted start.
- PH0 to PH1 on a rate change (downstream role), or on a TS1 run plus good error rate (upstream role).
- PH1 to IDLE with done (early exit), or PH1 to PH2.
- PH2 to PH3 on a tune-complete pulse, and PH3 to IDLE with done on a tune-complete pulse.
- Any phase to IDLE with fail when its timer expires.

Top module: `eq_phase_ctrl`

## Requirements
- R1: After reset the controller is idle: `eq_active`=0, `phase`=0, `ec_tx`=00b, `eq_done`=0, `eq_fail`=0, and all captured fields are zero.
- R2: A start request while `target_rate_ok` is low is ignored and the controller stays idle.
- R3: An accepted start enters phase 0, which transmits EC=00b. In phase 0 an upstream-role port captures the preset and hint from each valid TS1.
- R4: A TS1 whose 4-bit preset is above 10 is reserved. Neither its preset nor its hint is captured.
- R5: In phase 0 a downstream-role port (`role_dsp`=1) moves to phase 1 on `rate_chg_done`. An upstream-role port stays in phase 0 on that strobe.
- R6: An upstream-role port leaves phase 0 for phase 1 on the edge after it has seen two consecutive TS1s with the same EC, provided `ber_ok` is high on that edge.
- R7: An `os_bad` cycle zeroes the consecutive-TS1 count. A TS1 whose EC differs from the previous one restarts the count at one.
- R8: Phase 1 transmits EC=01b and captures Full Swing and Low Frequency from each valid TS1.
- R9: In phase 1, after two consecutive TS1s with `quality_ok` and `skip_tune` high, the port returns to idle with EC=00b and `eq_done`=1, without visiting phases 2 and 3.
- R10: In phase 1, after two consecutive TS1s with `quality_ok` high and `skip_tune` low, the port enters phase 2 and transmits EC=10b.
- R11: A `tune_done` pulse moves phase 2 to phase 3 (EC=11b). In phase 3 it ends the run in idle with `eq_done`=1. Phases never skip or go backwards while active.
- R12: A phase not left within `tmo_limit`+1 cycles of entry ends the run: idle, EC=00b, `eq_fail`=1. Done and fail are never high together.
- R13: An accepted start clears `eq_done` and `eq_fail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| role_dsp | input | 1 | 1 = downstream role, 0 = upstream role |
| eq_start | input | 1 | Request to begin equalization |
| target_rate_ok | input | 1 | Target rate is 8 GT/s or higher |
| rate_chg_done | input | 1 | Rate change completed strobe |
| ts1_valid | input | 1 | A TS1 was received this cycle |
| ts1_ec | input | 2 | EC field of the received TS1 |
| ts1_preset | input | PRESET_W | Requested transmitter preset |
| ts1_hint | input | HINT_W | Requested receiver hint |
| ts1_fs | input | FSLF_W | Partner Full Swing value |
| ts1_lf | input | FSLF_W | Partner Low Frequency value |
| os_bad | input | 1 | An invalid ordered set was seen this cycle |
| ber_ok | input | 1 | Error rate better than 1e-4 |
| quality_ok | input | 1 | Both ends report acceptable signal quality |
| skip_tune | input | 1 | Quality already sufficient; no fine tuning needed |
| tune_done | input | 1 | Current fine-tuning phase finished |
| tmo_limit | input | TMO_W | Per-phase timeout limit in cycles |
| eq_active | output | 1 | A phase is in progress |
| phase | output | 2 | Current phase number (0 when idle) |
| ec_tx | output | 2 | EC code to transmit |
| preset_q | output | PRESET_W | Captured preset |
| hint_q | output | HINT_W | Captured hint |
| fs_q | output | FSLF_W | Captured Full Swing |
| lf_q | output | FSLF_W | Captured Low Frequency |
| eq_done | output | 1 | Last run completed |
| eq_fail | output | 1 | Last run timed out |

## Verification
Each result is due one rising edge after the input that decides it:
- Phase, EC, the flags and the captured fields are all registered, so they change on the edge that samples the cause.
- An upstream TS1 run counts only after its second TS1 has been registered, so the phase step falls one edge later than that TS1.
- A timeout lands on edge `tmo_limit`+1 after phase entry.

The driver changes inputs at a falling edge and moves one rising edge forward. It then queues the expected values. The monitor compares them shortly after that same falling edge, so every comparison lands in the cycle worked out above.

// File: rtl/eq_phase_pkg.sv
package eq_phase_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PH0,
        ST_PH1,
        ST_PH2,
        ST_PH3
    } eq_state_e;

    localparam logic [1:0] EC_PH0 = 2'b00;
    localparam logic [1:0] EC_PH1 = 2'b01;
    localparam logic [1:0] EC_PH2 = 2'b10;
    localparam logic [1:0] EC_PH3 = 2'b11;

endpackage

// File: rtl/eq_ts1_tracker.sv
module eq_ts1_tracker #(
    parameter int RUN_LEN = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       ts1_valid,
    input  logic [1:0] ts1_ec,
    input  logic       os_bad,
    output logic       run_ok
);
    localparam int CW = $clog2(RUN_LEN + 1);
    localparam logic [CW-1:0] SAT = CW'(RUN_LEN);

    logic [CW-1:0] cnt_q;
    logic [1:0]    last_ec_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            last_ec_q <= 2'b00;
        end else if (clear || os_bad) begin
            cnt_q     <= '0;
        end else if (ts1_valid) begin
            last_ec_q <= ts1_ec;
            if (cnt_q != '0 && ts1_ec != last_ec_q)
                cnt_q <= CW'(1);
            else if (cnt_q != SAT)
                cnt_q <= cnt_q + CW'(1);
        end
    end

    assign run_ok = (cnt_q == SAT);
endmodule

// File: rtl/eq_phase_timer.sv
module eq_phase_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             running,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    logic [TMO_W-1:0] tmr_q;

    assign expired = running && (tmr_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tmr_q <= '0;
        else if (restart)
            tmr_q <= '0;
        else if (running && !expired)
            tmr_q <= tmr_q + TMO_W'(1);
    end
endmodule

// File: rtl/eq_param_latch.sv
module eq_param_latch #(
    parameter int PRESET_W   = 4,
    parameter int HINT_W     = 3,
    parameter int FSLF_W     = 6,
    parameter int PRESET_MAX = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_preset,
    input  logic                cap_fslf,
    input  logic [PRESET_W-1:0] preset_in,
    input  logic [HINT_W-1:0]   hint_in,
    input  logic [FSLF_W-1:0]   fs_in,
    input  logic [FSLF_W-1:0]   lf_in,
    output logic [PRESET_W-1:0] preset_q,
    output logic [HINT_W-1:0]   hint_q,
    output logic [FSLF_W-1:0]   fs_q,
    output logic [FSLF_W-1:0]   lf_q
);
    localparam logic [PRESET_W-1:0] PRESET_LIM = PRESET_W'(PRESET_MAX);

    logic preset_legal;
    assign preset_legal = (preset_in <= PRESET_LIM);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            preset_q <= '0;
            hint_q   <= '0;
        end else if (cap_preset && preset_legal) begin
            preset_q <= preset_in;
            hint_q   <= hint_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_q <= '0;
            lf_q <= '0;
        end else if (cap_fslf) begin
            fs_q <= fs_in;
            lf_q <= lf_in;
        end
    end
endmodule

// File: rtl/eq_phase_ctrl.sv
module eq_phase_ctrl
    import eq_phase_pkg::*;
#(
    parameter int PRESET_W   = 4,
    parameter int HINT_W     = 3,
    parameter int FSLF_W     = 6,
    parameter int TMO_W      = 16,
    parameter int PRESET_MAX = 10,
    parameter int TS1_RUN    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                role_dsp,
    input  logic                eq_start,
    input  logic                target_rate_ok,
    input  logic                rate_chg_done,
    input  logic                ts1_valid,
    input  logic [1:0]          ts1_ec,
    input  logic [PRESET_W-1:0] ts1_preset,
    input  logic [HINT_W-1:0]   ts1_hint,
    input  logic [FSLF_W-1:0]   ts1_fs,
    input  logic [FSLF_W-1:0]   ts1_lf,
    input  logic                os_bad,
    input  logic                ber_ok,
    input  logic                quality_ok,
    input  logic                skip_tune,
    input  logic                tune_done,
    input  logic [TMO_W-1:0]    tmo_limit,
    output logic                eq_active,
    output logic [1:0]          phase,
    output logic [1:0]          ec_tx,
    output logic [PRESET_W-1:0] preset_q,
    output logic [HINT_W-1:0]   hint_q,
    output logic [FSLF_W-1:0]   fs_q,
    output logic [FSLF_W-1:0]   lf_q,
    output logic                eq_done,
    output logic                eq_fail
);
    eq_state_e state_q, state_d;
    logic      set_done, set_fail, start_ok;
    logic      run_ok, expired, changing;

    assign start_ok = (state_q == ST_IDLE) && eq_start && target_rate_ok;
    assign changing = (state_d != state_q);

    // next-state decision; timeout outranks every advance
    always_comb begin
        state_d  = state_q;
        set_done = 1'b0;
        set_fail = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_ok)
                    state_d = ST_PH0;
            end
            ST_PH0: begin
                if (expired) begin
                    state_d  = ST_IDLE;
                    set_fail = 1'b1;
                end else if (role_dsp ? rate_chg_done : (run_ok && ber_ok)) begin
                    state_d = ST_PH1;
                end
            end
            ST_PH1: begin
                if (expired) begin
                    state_d  = ST_IDLE;
                    set_fail = 1'b1;
                end else if (run_ok && quality_ok) begin
                    if (skip_tune) begin
                        state_d  = ST_IDLE;
                        set_done = 1'b1;
                    end else begin
                        state_d = ST_PH2;
                    end
                end
            end
            ST_PH2: begin
                if (expired) begin
                    state_d  = ST_IDLE;
                    set_fail = 1'b1;
                end else if (tune_done) begin
                    state_d = ST_PH3;
                end
            end
            ST_PH3: begin
                if (expired) begin
                    state_d  = ST_IDLE;
                    set_fail = 1'b1;
                end else if (tune_done) begin
                    state_d  = ST_IDLE;
                    set_done = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // outputs decoded from the state register
    always_comb begin
        eq_active = 1'b1;
        phase     = 2'd0;
        ec_tx     = EC_PH0;
        unique case (state_q)
            ST_IDLE: eq_active = 1'b0;
            ST_PH0:  begin phase = 2'd0; ec_tx = EC_PH0; end
            ST_PH1:  begin phase = 2'd1; ec_tx = EC_PH1; end
            ST_PH2:  begin phase = 2'd2; ec_tx = EC_PH2; end
            ST_PH3:  begin phase = 2'd3; ec_tx = EC_PH3; end
            default: eq_active = 1'b0;
        endcase
    end

    // sticky completion flags, cleared by a new run
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eq_done <= 1'b0;
            eq_fail <= 1'b0;
        end else if (start_ok) begin
            eq_done <= 1'b0;
            eq_fail <= 1'b0;
        end else begin
            if (set_done) eq_done <= 1'b1;
            if (set_fail) eq_fail <= 1'b1;
        end
    end

    eq_ts1_tracker #(
        .RUN_LEN (TS1_RUN)
    ) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (changing || (state_q == ST_IDLE)),
        .ts1_valid (ts1_valid),
        .ts1_ec    (ts1_ec),
        .os_bad    (os_bad),
        .run_ok    (run_ok)
    );

    eq_phase_timer #(
        .TMO_W (TMO_W)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (changing),
        .running (state_q != ST_IDLE),
        .limit   (tmo_limit),
        .expired (expired)
    );

    eq_param_latch #(
        .PRESET_W   (PRESET_W),
        .HINT_W     (HINT_W),
        .FSLF_W     (FSLF_W),
        .PRESET_MAX (PRESET_MAX)
    ) u_lat (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_preset (ts1_valid && (state_q == ST_PH0) && !role_dsp),
        .cap_fslf   (ts1_valid && (state_q == ST_PH1)),
        .preset_in  (ts1_preset),
        .hint_in    (ts1_hint),
        .fs_in      (ts1_fs),
        .lf_in      (ts1_lf),
        .preset_q   (preset_q),
        .hint_q     (hint_q),
        .fs_q       (fs_q),
        .lf_q       (lf_q)
    );
endmodule

// File: rtl/eq_phase_ctrl_chk.sv
module eq_phase_ctrl_chk #(
    parameter int PRESET_W   = 4,
    parameter int PRESET_MAX = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic                role_dsp,
    input logic                eq_start,
    input logic                target_rate_ok,
    input logic                ber_ok,
    input logic                ts1_valid,
    input logic [PRESET_W-1:0] ts1_preset,
    input logic                eq_active,
    input logic [1:0]          phase,
    input logic [PRESET_W-1:0] preset_q,
    input logic                eq_done,
    input logic                eq_fail
);
    localparam logic [PRESET_W-1:0] LIM = PRESET_W'(PRESET_MAX);

    p_start_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eq_active) |-> $past(eq_start && target_rate_ok));

    p_reserved_preset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ts1_valid) && ($past(ts1_preset) > LIM)) |-> (preset_q == $past(preset_q)));

    p_usp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!role_dsp && eq_active && phase == 2'd0 && !ber_ok) |=> (phase == 2'd0));

    p_phase_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (eq_active && $past(eq_active)) |-> (phase == $past(phase) || phase == $past(phase) + 2'd1));

    p_flags_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(eq_done && eq_fail));

    p_fail_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eq_fail) |-> !eq_active);

    p_done_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eq_done) |-> (!eq_active && $past(eq_active) && ($past(phase) == 2'd1 || $past(phase) == 2'd3)));
endmodule

bind eq_phase_ctrl eq_phase_ctrl_chk #(
    .PRESET_W   (PRESET_W),
    .PRESET_MAX (PRESET_MAX)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .role_dsp       (role_dsp),
    .eq_start       (eq_start),
    .target_rate_ok (target_rate_ok),
    .ber_ok         (ber_ok),
    .ts1_valid      (ts1_valid),
    .ts1_preset     (ts1_preset),
    .eq_active      (eq_active),
    .phase          (phase),
    .preset_q       (preset_q),
    .eq_done        (eq_done),
    .eq_fail        (eq_fail)
);

// File: tb/eq_phase_ctrl_tb.sv
module eq_phase_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        role_dsp = 1'b0, eq_start = 1'b0, target_rate_ok = 1'b0;
    logic        rate_chg_done = 1'b0, ts1_valid = 1'b0, os_bad = 1'b0;
    logic        ber_ok = 1'b0, quality_ok = 1'b0, skip_tune = 1'b0, tune_done = 1'b0;
    logic [1:0]  ts1_ec = 2'd0;
    logic [3:0]  ts1_preset = 4'd0;
    logic [2:0]  ts1_hint = 3'd0;
    logic [5:0]  ts1_fs = 6'd0, ts1_lf = 6'd0;
    logic [15:0] tmo_limit = 16'd50;
    logic        eq_active, eq_done, eq_fail;
    logic [1:0]  phase, ec_tx;
    logic [3:0]  preset_q;
    logic [2:0]  hint_q;
    logic [5:0]  fs_q, lf_q;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        string tag;
        int    kind;
        int    exp;
    } item_t;
    item_t sb[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    eq_phase_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .role_dsp(role_dsp), .eq_start(eq_start),
        .target_rate_ok(target_rate_ok), .rate_chg_done(rate_chg_done),
        .ts1_valid(ts1_valid), .ts1_ec(ts1_ec), .ts1_preset(ts1_preset),
        .ts1_hint(ts1_hint), .ts1_fs(ts1_fs), .ts1_lf(ts1_lf), .os_bad(os_bad),
        .ber_ok(ber_ok), .quality_ok(quality_ok), .skip_tune(skip_tune),
        .tune_done(tune_done), .tmo_limit(tmo_limit), .eq_active(eq_active),
        .phase(phase), .ec_tx(ec_tx), .preset_q(preset_q), .hint_q(hint_q),
        .fs_q(fs_q), .lf_q(lf_q), .eq_done(eq_done), .eq_fail(eq_fail)
    );

    function automatic int actual(int kind);
        case (kind)
            0: return int'(eq_active);
            1: return int'(phase);
            2: return int'(ec_tx);
            3: return int'(eq_done);
            4: return int'(eq_fail);
            5: return int'(preset_q);
            6: return int'(hint_q);
            7: return int'(fs_q);
            default: return int'(lf_q);
        endcase
    endfunction

    function automatic string kname(int kind);
        case (kind)
            0: return "eq_active";
            1: return "phase";
            2: return "ec_tx";
            3: return "eq_done";
            4: return "eq_fail";
            5: return "preset_q";
            6: return "hint_q";
            7: return "fs_q";
            default: return "lf_q";
        endcase
    endfunction

    // monitor: compares queued expectations just after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if (actual(it.kind) != it.exp) begin
                    errors++;
                    $display("FAIL %s %s actual=%0d expected=%0d",
                             it.tag, kname(it.kind), actual(it.kind), it.exp);
                end
            end
        end
    end

    task automatic expect_v(string tag, int kind, int exp);
        item_t it;
        it.tag = tag;
        it.kind = kind;
        it.exp = exp;
        sb.push_back(it);
    endtask

    task automatic expect_st(string tag, int act, int ph, int ec, int dn, int fl);
        expect_v(tag, 0, act);
        expect_v(tag, 1, ph);
        expect_v(tag, 2, ec);
        expect_v(tag, 3, dn);
        expect_v(tag, 4, fl);
    endtask

    task automatic nb();
        @(negedge clk);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) nb();
        rst_n = 1'b1;
        nb();
        expect_st("R1 reset", 0, 0, 0, 0, 0);
        expect_v("R1 reset", 5, 0);
        expect_v("R1 reset", 7, 0);

        // R2: start without a qualifying target rate
        eq_start = 1'b1; target_rate_ok = 1'b0;
        nb(); eq_start = 1'b0;
        expect_v("R2 gated start", 0, 0);
        nb();
        expect_v("R2 still idle", 0, 0);

        // downstream run through all phases
        role_dsp = 1'b1; target_rate_ok = 1'b1; eq_start = 1'b1;
        nb(); eq_start = 1'b0;
        expect_st("R3 dsp phase0", 1, 0, 0, 0, 0);
        rate_chg_done = 1'b1;
        nb(); rate_chg_done = 1'b0;
        expect_st("R5 dsp rate change", 1, 1, 1, 0, 0);
        ts1_valid = 1'b1; ts1_ec = 2'd1; ts1_fs = 6'd40; ts1_lf = 6'd10;
        nb();
        expect_v("R8 fs capture", 7, 40);
        expect_v("R8 lf capture", 8, 10);
        nb(); ts1_valid = 1'b0;
        expect_v("R10 waits quality", 1, 1);
        quality_ok = 1'b1; skip_tune = 1'b0;
        nb(); quality_ok = 1'b0;
        expect_st("R10 phase2", 1, 2, 2, 0, 0);
        tune_done = 1'b1;
        nb(); tune_done = 1'b0;
        expect_st("R11 phase3", 1, 3, 3, 0, 0);
        nb();
        expect_v("R11 phase3 holds", 1, 3);
        tune_done = 1'b1;
        nb(); tune_done = 1'b0;
        expect_st("R11 done", 0, 0, 0, 1, 0);

        // upstream run with early exit
        role_dsp = 1'b0; eq_start = 1'b1;
        nb(); eq_start = 1'b0;
        expect_st("R13 usp start clears done", 1, 0, 0, 0, 0);
        ts1_valid = 1'b1; ts1_ec = 2'd0; ts1_preset = 4'd6; ts1_hint = 3'd3;
        nb();
        expect_v("R3 preset latch", 5, 6);
        expect_v("R3 hint latch", 6, 3);
        ts1_preset = 4'd12; ts1_hint = 3'd1;
        nb(); ts1_valid = 1'b0;
        expect_v("R4 reserved preset", 5, 6);
        expect_v("R4 reserved hint", 6, 3);
        ts1_preset = 4'd6; ts1_hint = 3'd3;
        rate_chg_done = 1'b1;
        nb(); rate_chg_done = 1'b0;
        expect_st("R5 usp ignores rate change", 1, 0, 0, 0, 0);
        os_bad = 1'b1;
        nb(); os_bad = 1'b0; ber_ok = 1'b1;
        nb();
        expect_st("R7 bad set zeroes run", 1, 0, 0, 0, 0);
        ts1_valid = 1'b1; ts1_ec = 2'd0;
        nb(); ts1_ec = 2'd1;
        nb(); ts1_valid = 1'b0;
        nb();
        expect_v("R7 ec change restarts run", 1, 0);
        ts1_valid = 1'b1; ts1_ec = 2'd1;
        nb(); ts1_valid = 1'b0;
        expect_v("R6 one edge after run", 1, 0);
        nb();
        expect_st("R6 usp phase1", 1, 1, 1, 0, 0);
        ber_ok = 1'b0;
        quality_ok = 1'b1; skip_tune = 1'b1;
        ts1_valid = 1'b1; ts1_ec = 2'd1; ts1_fs = 6'd30; ts1_lf = 6'd8;
        nb(); nb(); ts1_valid = 1'b0;
        expect_v("R8 fs second run", 7, 30);
        expect_v("R8 lf second run", 8, 8);
        nb();
        expect_st("R9 early exit", 0, 0, 0, 1, 0);
        quality_ok = 1'b0; skip_tune = 1'b0;

        // R12: timeout in phase 0
        tmo_limit = 16'd5; role_dsp = 1'b1; eq_start = 1'b1;
        nb(); eq_start = 1'b0;
        expect_st("R12 timed run start", 1, 0, 0, 0, 0);
        repeat (5) nb();
        expect_v("R12 before limit", 0, 1);
        nb();
        expect_st("R12 timeout", 0, 0, 0, 0, 1);

        // R13: restart clears fail
        eq_start = 1'b1;
        nb(); eq_start = 1'b0;
        expect_st("R13 restart clears fail", 1, 0, 0, 0, 0);
        nb();
        nb();
        finished = 1;
        report();
        $finish;
    end
endmodule